// File: doc/BRIEF.md
# Multi-Function Timer with Watchdog

This block derives three periodic services from one divider chain clocked by the bus clock. A prescaler divides the clock by four, and an eight-bit counter on that base tick raises an overflow flag every 1024 clocks. A further halving stage feeds a rate divider, which raises a real-time flag at one of four software-chosen periods. The selected real-time tick also feeds a divide-by-64 watchdog counter. That counter cannot be switched off, and when software does not service it in time it fires a one-clock internal reset pulse.

Software uses an 8-bit bus with an address, a write strobe, write data and combinational read data. The control/status register holds both flags, their enables and the rate field. Each flag is cleared by writing 1 to its own acknowledge bit. A second address accepts the watchdog service write. The interrupt request combines the enabled flags. The wait-mode input never pauses the chain or the watchdog.

Top module: `mft_watchdog`

## Requirements
- R1: The overflow flag (register bit 7) sets on the 1024th clock edge after reset is released and again every 1024 clock edges after that.
- R2: The control/status register is read at address 0 with bit 7 overflow flag, bit 6 real-time flag, bit 5 overflow enable, bit 4 real-time enable, bits 3 and 2 reading 0, and bits 1:0 the rate field. Writes to address 0 load bits 5, 4 and 1:0.
- R3: Rate field value n (0 to 3) sets the real-time flag every 2048·2^n clock edges of the shared chain, counted in real-time base periods of 2048 clocks.
- R4: Writing 1 to bit 3 of address 0 clears the overflow flag, and writing 1 to bit 2 clears the real-time flag. If a flag is set and cleared in the same cycle, it ends up set.
- R5: `irq` is high exactly when (overflow flag and bit 5) or (real-time flag and bit 4) holds.
- R6: On the 64th selected real-time tick since the last watchdog clear, `wdog_rst` is high for exactly one cycle, starting at that tick's clock edge.
- R7: A write to address 1 with data bit 0 equal to 0 clears the watchdog count. A write there with bit 0 equal to 1 has no effect on the timeout.
- R8: Asserting `wait_in` does not slow or stop the chain or the watchdog.
- R9: After reset the register reads 0x03 (rate 11, flags and enables 0), `irq` is 0 and `wdog_rst` is 0.
- R10: A watchdog expiry restarts the whole divider chain, including the rate divider, from zero, and leaves the register contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wait_in | input | 1 | CPU wait-mode indication (timers keep running) |
| bus_addr | input | ADDR_W | Register address (0 control/status, 1 watchdog service) |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Interrupt request |
| wdog_rst | output | 1 | One-cycle watchdog reset pulse |

## Verification
The chain is run at the three rate settings, one after another. Rate 00 shows that the flag appears on every base period. Rate 01 shows that every other period is skipped. Rate 11, applied after an expiry, shows whether the rate divider really restarted, because the first tick lands at a different edge if it did not.

Flags are raised with their enables on and off, which separates flag logic from request logic. One acknowledge is timed onto a set edge so the priority between set and clear can be seen. The watchdog is serviced once with bit 0 at 0 and once with bit 0 at 1, and it runs through a long wait-mode window, so the exact expiry edge shows which writes took effect and that wait has no influence.

// File: rtl/mftw_pkg.sv
// Shared constants and types for the multi-function timer.
// Assumes an 8-bit register bus and a 2-bit rate field.
package mftw_pkg;
    localparam int unsigned DATA_W       = 8;
    localparam int unsigned RATE_W       = 2;
    localparam int unsigned BIT_TOF      = 7;
    localparam int unsigned BIT_RTIF     = 6;
    localparam int unsigned BIT_TOFIE    = 5;
    localparam int unsigned BIT_RTIE     = 4;
    localparam int unsigned BIT_ACK_TOF  = 3;
    localparam int unsigned BIT_ACK_RTIF = 2;

    typedef logic [RATE_W-1:0] rate_t;
    localparam rate_t RATE_RESET = '1;

    typedef struct packed {
        logic  tof_ie;
        logic  rti_ie;
        rate_t rate;
    } ctrl_t;
endpackage

// File: rtl/mftw_chain.sv
// Prescaler, overflow counter and halving stage of the shared divider chain.
// Assumes PRE_DIV >= 2. A clear restarts every stage from zero.
module mftw_chain #(
    parameter int unsigned PRE_DIV  = 4,
    parameter int unsigned OVF_BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic ovf_evt,
    output logic rti_base_evt
);
    localparam int unsigned PRE_W = $clog2(PRE_DIV);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

    logic [PRE_W-1:0]    pre_q;
    logic [OVF_BITS-1:0] ovf_q;
    logic                half_q;
    logic                base_tick;

    assign base_tick    = (pre_q == PRE_LAST);
    assign ovf_evt      = base_tick && (&ovf_q);
    assign rti_base_evt = ovf_evt && half_q;

    // Free-running prescaler producing the base tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  pre_q <= '0;
        else if (base_tick) pre_q <= '0;
        else                pre_q <= pre_q + 1'b1;
    end

    // Overflow counter advanced by the base tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  ovf_q <= '0;
        else if (base_tick) ovf_q <= ovf_q + 1'b1;
    end

    // Halving stage turning overflows into the real-time base.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) half_q <= 1'b0;
        else if (ovf_evt)  half_q <= ~half_q;
    end
endmodule

// File: rtl/mftw_rate_sel.sv
// Rate divider: passes one of every 2^rate real-time base events.
// Assumes the rate input is stable or its changes take effect at the next event.
module mftw_rate_sel #(
    parameter int unsigned RATE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              base_evt,
    input  logic [RATE_W-1:0] rate,
    output logic              rti_tick
);
    localparam int unsigned NUM_RATES = 1 << RATE_W;
    localparam int unsigned CNT_W     = NUM_RATES - 1;

    logic [CNT_W-1:0]     cnt_q;
    logic [NUM_RATES-1:0] ready;

    assign ready[0] = 1'b1;
    for (genvar k = 1; k < NUM_RATES; k++) begin : g_ready
        assign ready[k] = &cnt_q[k-1:0];
    end

    assign rti_tick = base_evt && ready[rate];

    // Counts base events so each rate can pick its slice.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt_q <= '0;
        else if (base_evt) cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/mftw_wdog.sv
// Always-on watchdog: counts real-time ticks and pulses on the DIV-th one.
// Assumes a service clear outranks both counting and expiry in the same cycle.
module mftw_wdog #(
    parameter int unsigned DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic svc_clr,
    output logic expire,
    output logic wdog_rst
);
    localparam int unsigned CNT_W = $clog2(DIV);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    assign expire = tick && (cnt_q == CNT_LAST) && !svc_clr;

    // Timeout counter, cleared by service or by its own expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (svc_clr || expire) cnt_q <= '0;
        else if (tick)              cnt_q <= cnt_q + 1'b1;
    end

    // One-cycle reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) wdog_rst <= 1'b0;
        else        wdog_rst <= expire;
    end
endmodule

// File: rtl/mftw_csr.sv
// Control/status register: flags with set-wins acknowledge, enables, rate field,
// read mux and interrupt request. Assumes the event inputs are one-cycle pulses.
module mftw_csr
    import mftw_pkg::*;
#(
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned CSR_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              ovf_evt,
    input  logic              rti_tick,
    output rate_t             rate,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              tof,
    output logic              rtif
);
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(CSR_ADDR);

    ctrl_t ctrl_q;
    logic  hit;
    logic  csr_wr;

    assign hit    = (bus_addr == MY_ADDR);
    assign csr_wr = bus_we && hit;
    assign rate   = ctrl_q.rate;

    // Writable control fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '{tof_ie: 1'b0, rti_ie: 1'b0, rate: RATE_RESET};
        end else if (csr_wr) begin
            ctrl_q.tof_ie <= bus_wdata[BIT_TOFIE];
            ctrl_q.rti_ie <= bus_wdata[BIT_RTIE];
            ctrl_q.rate   <= bus_wdata[RATE_W-1:0];
        end
    end

    // Overflow flag: a set beats a same-cycle acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)                               tof <= 1'b0;
        else if (ovf_evt)                         tof <= 1'b1;
        else if (csr_wr && bus_wdata[BIT_ACK_TOF]) tof <= 1'b0;
    end

    // Real-time flag: a set beats a same-cycle acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)                                rtif <= 1'b0;
        else if (rti_tick)                         rtif <= 1'b1;
        else if (csr_wr && bus_wdata[BIT_ACK_RTIF]) rtif <= 1'b0;
    end

    // Read mux; acknowledge bits always read zero.
    always_comb begin
        bus_rdata = '0;
        if (hit) begin
            bus_rdata[BIT_TOF]      = tof;
            bus_rdata[BIT_RTIF]     = rtif;
            bus_rdata[BIT_TOFIE]    = ctrl_q.tof_ie;
            bus_rdata[BIT_RTIE]     = ctrl_q.rti_ie;
            bus_rdata[RATE_W-1:0]   = ctrl_q.rate;
        end
    end

    // Interrupt request from the enabled flags.
    assign irq = (tof && ctrl_q.tof_ie) || (rtif && ctrl_q.rti_ie);
endmodule

// File: rtl/mft_watchdog.sv
// Top: a shared divider chain feeding the overflow flag, the real-time flag and
// an always-on watchdog. Assumes a single clock and synchronous active-low reset.
module mft_watchdog
    import mftw_pkg::*;
#(
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned CSR_ADDR = 0,
    parameter int unsigned SVC_ADDR = 1,
    parameter int unsigned PRE_DIV  = 4,
    parameter int unsigned OVF_BITS = 8,
    parameter int unsigned WDOG_DIV = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wait_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq,
    output logic              wdog_rst
);
    localparam logic [ADDR_W-1:0] SVC_A = ADDR_W'(SVC_ADDR);

    logic  ovf_evt;
    logic  rti_base_evt;
    logic  rti_tick;
    logic  wd_tick;
    logic  wd_expire;
    logic  svc_clr;
    logic  run_en;
    logic  tof_flag;
    logic  rtif_flag;
    rate_t rate;

    // The watchdog ignores wait mode: counting is enabled in either state.
    assign run_en  = wait_in | 1'b1;
    assign wd_tick = rti_tick && run_en;
    assign svc_clr = bus_we && (bus_addr == SVC_A) && !bus_wdata[0];

    mftw_chain #(.PRE_DIV(PRE_DIV), .OVF_BITS(OVF_BITS)) u_chain (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (wd_expire),
        .ovf_evt      (ovf_evt),
        .rti_base_evt (rti_base_evt)
    );

    mftw_rate_sel #(.RATE_W(RATE_W)) u_rate (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (wd_expire),
        .base_evt (rti_base_evt),
        .rate     (rate),
        .rti_tick (rti_tick)
    );

    mftw_wdog #(.DIV(WDOG_DIV)) u_wdog (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (wd_tick),
        .svc_clr  (svc_clr),
        .expire   (wd_expire),
        .wdog_rst (wdog_rst)
    );

    mftw_csr #(.ADDR_W(ADDR_W), .CSR_ADDR(CSR_ADDR)) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .ovf_evt   (ovf_evt),
        .rti_tick  (rti_tick),
        .rate      (rate),
        .bus_rdata (bus_rdata),
        .irq       (irq),
        .tof       (tof_flag),
        .rtif      (rtif_flag)
    );
endmodule

// File: rtl/mftw_checker.sv
// Temporal checks for mft_watchdog, attached with bind below.
module mftw_checker #(
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned CSR_ADDR = 0,
    parameter int unsigned SVC_ADDR = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [7:0]        bus_wdata,
    input logic              irq,
    input logic              wdog_rst,
    input logic              ovf_evt,
    input logic              rti_tick,
    input logic              tof,
    input logic              rtif
);
    localparam logic [ADDR_W-1:0] CA = ADDR_W'(CSR_ADDR);
    localparam logic [ADDR_W-1:0] SA = ADDR_W'(SVC_ADDR);

    AST_TOF_NEEDS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tof) |-> $past(ovf_evt)); // R1
    AST_RTIF_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rtif) |-> $past(rti_tick)); // R3
    AST_TOF_CLEAR_BY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tof) |-> $past(bus_we && bus_addr == CA && bus_wdata[3])); // R4
    AST_RTIF_CLEAR_BY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rtif) |-> $past(bus_we && bus_addr == CA && bus_wdata[2])); // R4
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (tof || rtif)); // R5
    AST_WDOG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst |=> !wdog_rst); // R6
    AST_WDOG_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst |-> $past(rti_tick)); // R6
    AST_SVC_BLOCKS_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_we && bus_addr == SA && !bus_wdata[0]) |-> !wdog_rst); // R7
endmodule

bind mft_watchdog mftw_checker #(
    .ADDR_W   (ADDR_W),
    .CSR_ADDR (CSR_ADDR),
    .SVC_ADDR (SVC_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .wdog_rst  (wdog_rst),
    .ovf_evt   (ovf_evt),
    .rti_tick  (rti_tick),
    .tof       (tof_flag),
    .rtif      (rtif_flag)
);

// File: tb/sim_mft_watchdog.sv
// Scoreboard bench: the driver queues expected outputs per cycle and a
// negedge monitor compares them as the design produces them.
module sim_mft_watchdog;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 180000;
    localparam logic [3:0] A_CSR = 4'd0;
    localparam logic [3:0] A_SVC = 4'd1;
    localparam int K_RD = 0, K_IRQ = 1, K_WD = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wait_in = 1'b0;
    logic [3:0] bus_addr = A_CSR;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq;
    logic       wdog_rst;

    int cyc = 0;
    int checks = 0;
    int errors = 0;

    typedef struct {
        int         at;
        int         kind;
        logic [7:0] exp;
        string      req;
    } item_t;
    item_t sb[$];
    item_t cur;

    always #(CLK_PERIOD/2) clk = ~clk;

    mft_watchdog u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .wait_in   (wait_in),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq),
        .wdog_rst  (wdog_rst)
    );

    // Counts clock edges since reset release.
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cyc=%0d actual=%02h expected=%02h", req, cyc, act, exp);
        end
    endtask

    task automatic expect_at(input int at, input int kind, input logic [7:0] exp, input string req);
        item_t it;
        it.at = at; it.kind = kind; it.exp = exp; it.req = req;
        sb.push_back(it);
    endtask

    task automatic write_at(input int n, input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        while (cyc < n - 1) @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = A_CSR; bus_wdata = 8'h00;
    endtask

    // Monitor: pops due items and compares with the outputs.
    always @(negedge clk) begin
        if (rst_n) begin
            while (sb.size() > 0 && sb[0].at <= cyc) begin
                logic [7:0] act;
                cur = sb.pop_front();
                case (cur.kind)
                    K_RD:    act = bus_rdata;
                    K_IRQ:   act = {7'd0, irq};
                    default: act = {7'd0, wdog_rst};
                endcase
                checks++;
                if (cur.at != cyc || act !== cur.exp) begin
                    errors++;
                    $display("FAIL %s cyc=%0d kind=%0d actual=%02h expected=%02h",
                             cur.req, cyc, cur.kind, act, cur.exp);
                end
            end
        end
    end

    // Wait mode held high over a long stretch of the watchdog run (R8).
    initial begin
        @(negedge clk);
        while (cyc < 20000) @(negedge clk);
        wait_in = 1'b1;
        while (cyc < 100000) @(negedge clk);
        wait_in = 1'b0;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        errors++;
        $display("FAIL timeout cyc=%0d actual=running expected=done", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(bus_rdata, 8'h03, "R9 reset register");
        check({7'd0, irq}, 8'h00, "R9 reset irq");
        check({7'd0, wdog_rst}, 8'h00, "R9 reset wdog_rst");
        rst_n = 1'b1;

        // Overflow, real-time rates, acknowledge and enables.
        expect_at(1023,  K_RD,  8'h20, "R1 before first overflow");
        expect_at(1023,  K_IRQ, 8'h00, "R5 no flag no irq");
        expect_at(1024,  K_RD,  8'hA0, "R1 overflow at 1024");
        expect_at(1024,  K_IRQ, 8'h01, "R5 enabled overflow irq");
        expect_at(1030,  K_RD,  8'h20, "R4 overflow ack");
        expect_at(1030,  K_IRQ, 8'h00, "R4 irq drops after ack");
        expect_at(2047,  K_RD,  8'h20, "R3 rate 00 before tick");
        expect_at(2048,  K_RD,  8'hE0, "R3 rate 00 tick at 2048");
        expect_at(2050,  K_RD,  8'h11, "R2 register write and acks");
        expect_at(2050,  K_IRQ, 8'h00, "R4 both acks");
        expect_at(3072,  K_RD,  8'h91, "R1 overflow at 3072");
        expect_at(3072,  K_IRQ, 8'h00, "R5 disabled overflow no irq");
        expect_at(4095,  K_RD,  8'h91, "R3 rate 01 skips 2048 slot");
        expect_at(4096,  K_RD,  8'hD1, "R3 rate 01 tick at 4096");
        expect_at(4096,  K_IRQ, 8'h01, "R5 enabled rti irq");
        expect_at(5000,  K_RD,  8'h91, "R4 rti ack");
        expect_at(8191,  K_RD,  8'h91, "R3 rate 01 no tick at 6144");
        expect_at(8192,  K_RD,  8'hD1, "R4 set wins over ack");
        expect_at(8192,  K_IRQ, 8'h01, "R4 set wins irq");
        expect_at(8220,  K_RD,  8'hD0, "R2 rate 00 written");
        // Watchdog: cleared at 8200, ineffective write at 10300, 64th tick at 139264.
        expect_at(139263, K_WD, 8'h00, "R7 no early expiry");
        expect_at(139264, K_WD, 8'h01, "R6 R8 expiry on 64th tick");
        expect_at(139265, K_WD, 8'h00, "R6 one-cycle pulse");
        expect_at(139265, K_RD, 8'hD0, "R10 register kept");
        expect_at(139270, K_RD, 8'h13, "R4 acks with rate 11");
        expect_at(140287, K_RD, 8'h13, "R10 chain restarted");
        expect_at(140288, K_RD, 8'h93, "R1 overflow after restart");
        expect_at(155647, K_RD, 8'h93, "R10 rate divider restarted");
        expect_at(155647, K_IRQ, 8'h00, "R10 no early rti");
        expect_at(155648, K_RD, 8'hD3, "R10 R3 rate 11 tick");
        expect_at(155648, K_IRQ, 8'h01, "R5 rti irq");

        write_at(1,      A_CSR, 8'h20);
        write_at(1030,   A_CSR, 8'h28);
        write_at(2050,   A_CSR, 8'h1D);
        write_at(5000,   A_CSR, 8'h15);
        write_at(8192,   A_CSR, 8'h15);
        write_at(8200,   A_SVC, 8'h00);
        write_at(8220,   A_CSR, 8'h10);
        write_at(10300,  A_SVC, 8'h01);
        write_at(139270, A_CSR, 8'h1F);

        while (cyc < 155660) @(negedge clk);
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL scoreboard actual=%0d expected=0 items left", sb.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule